// File: doc/BRIEF.md
# Compare-Capture Timer Event Counter

This block is a free-running up-counter that is paced either by a tap of an internal divide chain or by qualified transitions on one external input pin. Two compare registers each raise a one-cycle interrupt pulse when the counter steps onto their value. The second compare register can also act as a period register, returning the counter to zero after the matching value. A capture register takes a snapshot of the counter on each qualified pin transition.

The external pin passes through a two-flop synchroniser and then a single edge qualifier. That qualifier drives three things from the same pulse: the external interrupt, the capture strobe and, when selected, the count tick. Software configures the block through a small word-wide register port. Reads are registered, so read data is valid one cycle after the request.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter, capture, both compare registers and the control register read back as zero, and all three interrupt outputs are low.
- R2: While control bit 0 (run) is 0 the counter holds its value. While it is 1 the counter advances by one on every count tick.
- R3: Control bits 7:4 select the count source. Codes 0 to 5 give one tick every 2^(code+1) clock cycles, which is a division by 2, 4, 8, 16, 32 or 64.
- R4: Select code 7 makes every qualified pin edge a count tick. Codes 6 and 8 to 15 produce no ticks, so the counter stays where it is.
- R5: Each compare register raises its own interrupt output for exactly one cycle when a tick moves the counter onto that register's value. The pulse is high in the same cycle in which the counter shows the value.
- R6: With control bit 1 set, the tick that follows the counter equalling compare register 1 loads zero. The period is then compare1+1 ticks, and a compare 0 value above compare 1 never pulses.
- R7: With control bit 1 clear, the counter wraps from its maximum value to zero. The period is then 2^W ticks.
- R8: Control bits 3:2 qualify pin transitions: 00 rising, 01 falling, 10 both directions, 11 none. A qualified transition makes the external interrupt pulse in the third clock cycle after the pin changes.
- R9: On a qualified edge the capture register loads the value the counter held just before that edge's own tick. It keeps that value until the next qualified edge.
- R10: Addresses are 0 control, 1 compare 0, 2 compare 1, 3 capture and 4 counter. Capture and counter ignore writes.
- R11: A read of the capture register issued on the same clock edge that loads a new capture value returns the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; data is valid the next cycle |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Registered read data |
| ext_pin | input | 1 | Asynchronous external input |
| irq_cmp0 | output | 1 | Compare 0 match pulse |
| irq_cmp1 | output | 1 | Compare 1 match pulse |
| irq_ext | output | 1 | Qualified external edge pulse |

## Verification
A register read returns its data one cycle after the strobe. The bench therefore samples read data at the falling edge that follows the rising edge which served the request. An external pin change shows up on the interrupt output at exactly the third falling edge after the change, and every toggle checks that slot and no other. Prescaler rates are measured as the counter difference between two reads a whole number of periods apart, so the free-running divider phase cancels out. Compare periods are measured as the cycle distance between consecutive interrupt pulses.

// File: rtl/cct_pkg.sv
package cct_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_mode_e;

  // run is bit 0, clr_on_m1 bit 1, edge_mode bits 3:2, clk_sel bits 7:4
  typedef struct packed {
    logic [3:0] clk_sel;
    edge_mode_e edge_mode;
    logic       clr_on_m1;
    logic       run;
  } ctrl_t;

  localparam logic [3:0] SEL_EXT = 4'd7;

  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_CMP0  = 3'd1;
  localparam logic [2:0] ADR_CMP1  = 3'd2;
  localparam logic [2:0] ADR_CAPT  = 3'd3;
  localparam logic [2:0] ADR_COUNT = 3'd4;

  function automatic logic edge_qualify(edge_mode_e m, logic cur, logic prev);
    case (m)
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int TAPS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tap_pulse
);
  logic [TAPS-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // tap k fires once every 2^(k+1) cycles
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap_pulse[k] = &div_q[k:0];
  end
endmodule

// File: rtl/cct_edge_det.sv
module cct_edge_det
  import cct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       edge_pulse
);
  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign edge_pulse = edge_qualify(mode, sync2_q, prev_q);
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clr_on_m1,
  input  logic [W-1:0] cmp0,
  input  logic [W-1:0] cmp1,
  output logic [W-1:0] count,
  output logic         irq0,
  output logic         irq1
);
  function automatic logic [W-1:0] step(logic [W-1:0] cur, logic [W-1:0] lim,
                                        logic clr);
    return (clr && cur == lim) ? '0 : cur + 1'b1;
  endfunction

  logic         advance;
  logic [W-1:0] count_nx;

  assign advance  = run && tick;
  assign count_nx = step(count, cmp1, clr_on_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      irq0  <= 1'b0;
      irq1  <= 1'b0;
    end else begin
      irq0 <= advance && (count_nx == cmp0);
      irq1 <= advance && (count_nx == cmp1);
      if (advance) count <= count_nx;
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int W    = 16,
  parameter int TAPS = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         ext_pin,
  output logic         irq_cmp0,
  output logic         irq_cmp1,
  output logic         irq_ext
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl_q;
  logic [W-1:0]    cmp0_q, cmp1_q, capt_q, count;
  logic [TAPS-1:0] taps;
  logic            ext_edge, tick, cap_strobe;

  cct_prescaler #(.TAPS(TAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap_pulse(taps));

  cct_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .mode(ctrl_q.edge_mode), .edge_pulse(ext_edge));

  assign cap_strobe = ext_edge;

  always_comb begin
    tick = 1'b0;
    for (int k = 0; k < TAPS; k++)
      if (ctrl_q.clk_sel == 4'(k)) tick = taps[k];
    if (ctrl_q.clk_sel == SEL_EXT) tick = ext_edge;
  end

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick(tick),
    .clr_on_m1(ctrl_q.clr_on_m1), .cmp0(cmp0_q), .cmp1(cmp1_q),
    .count(count), .irq0(irq_cmp0), .irq1(irq_cmp1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp0_q <= '0;
      cmp1_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_CTRL: ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        ADR_CMP0: cmp0_q <= reg_wdata;
        ADR_CMP1: cmp1_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q  <= '0;
      irq_ext <= 1'b0;
    end else begin
      irq_ext <= ext_edge;
      if (cap_strobe) capt_q <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADR_CTRL:  reg_rdata <= W'(ctrl_q);
        ADR_CMP0:  reg_rdata <= cmp0_q;
        ADR_CMP1:  reg_rdata <= cmp1_q;
        ADR_CAPT:  reg_rdata <= capt_q;
        ADR_COUNT: reg_rdata <= count;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         clr_en,
  input logic [3:0]   clk_sel,
  input logic         tick,
  input logic         cap_strobe,
  input logic [W-1:0] count,
  input logic [W-1:0] capt,
  input logic [W-1:0] cmp0,
  input logic [W-1:0] cmp1,
  input logic         irq_cmp0,
  input logic         irq_ext
);
  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R2
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !(clr_en && count == cmp1)) |=> count == W'($past(count) + 1'b1));

  // R4
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 4'd6 || clk_sel[3]) |-> !tick);

  // R5
  cmp0_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp0 && $stable(cmp0)) |-> count == cmp0);

  // R6
  period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && clr_en && count == cmp1) |=> count == '0);

  // R8
  ext_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> irq_ext);

  // R9
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> capt == $past(count));

  // R9
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> $stable(capt));
endmodule

bind cct_timer cct_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .clr_en(ctrl_q.clr_on_m1),
  .clk_sel(ctrl_q.clk_sel), .tick(tick), .cap_strobe(cap_strobe),
  .count(count), .capt(capt_q), .cmp0(cmp0_q), .cmp1(cmp1_q),
  .irq_cmp0(irq_cmp0), .irq_ext(irq_ext));

// File: tb/tb_cct_timer.sv
module tb_cct_timer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         ext_pin = 1'b0;
  logic         irq_cmp0, irq_cmp1, irq_ext;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cct_timer #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_pin = 1'b0; reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    reg_addr = a; reg_wdata = W'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = int'(reg_rdata);
  endtask

  function automatic int ctrl(input int sel, input int em, input int clr, input int run);
    return (sel << 4) | (em << 2) | (clr << 1) | run;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b, v, ta, tb, tc, n0, p;
    do_reset();

    // R1: reset state
    for (int r = 0; r < 5; r++) begin
      rd(3'(r), v);
      chk(v == 0, "R1 reset reg", v, 0);
    end
    chk(!irq_cmp0 && !irq_cmp1 && !irq_ext, "R1 irqs low", int'({irq_cmp0, irq_cmp1, irq_ext}), 0);

    // R2: stop holds the count
    wr(3'd0, ctrl(0, 0, 0, 1));
    repeat (20) @(negedge clk);
    wr(3'd0, ctrl(0, 0, 0, 0));
    rd(3'd4, a);
    repeat (40) @(negedge clk);
    rd(3'd4, b);
    chk(a != 0 && a == b, "R2 hold while stopped", b, a);

    // R3: divider taps
    for (int s = 0; s < 6; s++) begin
      do_reset();
      p = 1 << (s + 1);
      wr(3'd0, ctrl(s, 0, 0, 1));
      rd(3'd4, a);
      repeat (4 * p - 1) @(negedge clk);
      rd(3'd4, b);
      chk(((b - a) & 8'hff) == 4, $sformatf("R3 sel %0d ticks", s), (b - a) & 8'hff, 4);
    end

    // R4: reserved select codes stay still
    foreach (a_sel_list[i]) begin end
    for (int s = 6; s < 16; s += 3) begin
      do_reset();
      wr(3'd0, ctrl(s, 0, 0, 1));
      repeat (100) @(negedge clk);
      rd(3'd4, v);
      chk(v == 0, $sformatf("R4 reserved sel %0d", s), v, 0);
    end

    // R5 R6: clear-on-match periods, divide by 2
    for (int c = 1; c < 8; c += 3) begin
      do_reset();
      wr(3'd1, c / 2);
      wr(3'd2, c);
      wr(3'd0, ctrl(0, 0, 1, 1));
      ta = -1; tb = -1; tc = -1; n0 = -1;
      for (int t = 0; t < (c + 1) * 2 * 3 + 20; t++) begin
        @(negedge clk);
        if (irq_cmp1) begin
          if (ta < 0) ta = t; else if (tb < 0) tb = t;
        end
        if (irq_cmp0) begin
          if (n0 < 0) n0 = t; else if (tc < 0) tc = t;
        end
        if (irq_cmp1 && t > 0) begin
          @(negedge clk); t++;
          chk(!irq_cmp1, "R5 one-cycle pulse", int'(irq_cmp1), 0);
        end
      end
      chk(tb - ta == (c + 1) * 2, $sformatf("R6 period cmp1=%0d", c), tb - ta, (c + 1) * 2);
      chk(tc - n0 == (c + 1) * 2, $sformatf("R5 cmp0 period cmp1=%0d", c), tc - n0, (c + 1) * 2);
    end

    // R6: compare 0 beyond the period never fires
    do_reset();
    wr(3'd1, 9);
    wr(3'd2, 4);
    wr(3'd0, ctrl(0, 0, 1, 1));
    n0 = 0;
    repeat (100) begin
      @(negedge clk);
      if (irq_cmp0) n0++;
    end
    chk(n0 == 0, "R6 cmp0 above cmp1 silent", n0, 0);

    // R7: wrap without clear, period 2^W ticks
    do_reset();
    wr(3'd1, 5);
    wr(3'd0, ctrl(0, 0, 0, 1));
    ta = -1; tb = -1;
    for (int t = 0; t < 1200; t++) begin
      @(negedge clk);
      if (irq_cmp0) begin
        if (ta < 0) ta = t; else if (tb < 0) tb = t;
      end
    end
    chk(tb - ta == 512, "R7 wrap period", tb - ta, 512);

    // R8 R9 R4: edge modes with external counting
    for (int m = 0; m < 4; m++) begin
      int expn;
      do_reset();
      wr(3'd0, ctrl(7, m, 0, 1));
      repeat (5) @(negedge clk);
      expn = 0;
      for (int t = 0; t < 6; t++) begin
        bit valid;
        int seen, bad;
        ext_pin = ~ext_pin;
        valid = (m == 0 && ext_pin) || (m == 1 && !ext_pin) || (m == 2);
        seen = 0; bad = 0;
        for (int j = 1; j <= 5; j++) begin
          @(negedge clk);
          if (irq_ext) begin
            if (j == 3) seen++; else bad++;
          end
        end
        chk(seen == int'(valid) && bad == 0, $sformatf("R8 mode %0d toggle %0d", m, t), seen, int'(valid));
        if (valid) expn++;
      end
      rd(3'd4, v);
      chk(v == expn, $sformatf("R4 ext count mode %0d", m), v, expn);
      rd(3'd3, v);
      chk(v == (expn > 0 ? expn - 1 : 0), $sformatf("R9 capture mode %0d", m), v, expn > 0 ? expn - 1 : 0);
    end

    // R11 R10: read colliding with a capture, then write to read-only registers
    do_reset();
    wr(3'd0, ctrl(7, 0, 0, 1));
    ext_pin = 1'b1; repeat (6) @(negedge clk);
    ext_pin = 1'b0; repeat (6) @(negedge clk);
    ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(3'd3, v);
    chk(v == 0, "R11 same-cycle read old", v, 0);
    rd(3'd3, v);
    chk(v == 1, "R9 new capture", v, 1);
    wr(3'd3, 55);
    wr(3'd4, 77);
    rd(3'd3, v);
    chk(v == 1, "R10 capture ignores write", v, 1);
    rd(3'd4, v);
    chk(v == 2, "R10 counter ignores write", v, 2);
    wr(3'd2, 33);
    rd(3'd2, v);
    chk(v == 33, "R10 cmp1 readback", v, 33);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int a_sel_list[1];
endmodule